// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit produces the address stream for a load or store that moves several registers in one operation. A single start pulse captures a base address, a 16-bit register-select mask, an addressing mode, a writeback request, an execution-state flag and a rule for register 15. After that, the unit issues one beat per cycle. Each beat carries a word address and the register index it belongs to. Registers are visited from the lowest index upward, and the lowest index always gets the lowest address. A completion pulse ends the operation. When writeback was requested, the completion pulse also carries the updated base value.

The mode selects both the direction and whether the base address itself is included in the range. The unit checks each request before it issues any beat. If the mode is not allowed in the current execution state, or if register 15 breaks the rule given for the instruction, the request completes at once, is flagged as illegal and produces no beats.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `wb_valid` and `beat_valid` are all low.
- R2: An accepted request with N set mask bits gives exactly N beats in N consecutive cycles. The first beat appears on the cycle after the start edge. `beat_reg` rises strictly from beat to beat, and each beat names one set mask bit.
- R3: Consecutive beat addresses differ by +4. The first address depends on the mode: base (mode 0, increment-after), base+4 (mode 1, increment-before), base−4N+4 (mode 2, decrement-after) or base−4N (mode 3, decrement-before). All arithmetic wraps modulo 2^32.
- R4: Mode code 0 is increment-after and is the default encoding. A request with `mode` = 0 behaves as increment-after.
- R5: `wb_valid` goes high together with `done` only if `wback` was set at start. `new_base` then equals base+4N for modes 0 and 1, or base−4N for modes 2 and 3.
- R6: If `alt_state` is 1 and `mode` is 1 or 3, the request completes on the next cycle with `done` = 1, `illegal` = 1, no beats and no `wb_valid`. Modes 0 and 2 stay legal when `alt_state` is 1.
- R7: `pc_rule` = 1 forbids mask bit 15, and `pc_rule` = 2 requires it. A request that breaks its rule is handled as an illegal request, in the same way as in R6. `pc_rule` values 0 and 3 place no constraint on bit 15.
- R8: An empty mask completes on the cycle after start with `done` = 1 and no beats. If writeback was requested, `new_base` equals the base.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running transfer continues unchanged, and no extra beat or completion appears.
- R10: `done` rises in the cycle right after the last beat. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| base | input | 32 | Base address |
| reg_mask | input | 16 | Register select, bit i selects register i |
| mode | input | 2 | 0 incr-after, 1 incr-before, 2 decr-after, 3 decr-before |
| wback | input | 1 | Request the updated base |
| alt_state | input | 1 | Second execution state, before-modes illegal |
| pc_rule | input | 2 | 0/3 free, 1 forbid bit 15, 2 require bit 15 |
| busy | output | 1 | Beats in progress |
| beat_valid | output | 1 | Beat present this cycle |
| beat_addr | output | 32 | Word address of the beat |
| beat_reg | output | 4 | Register index of the beat |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Qualifies `done`: request rejected |
| wb_valid | output | 1 | Qualifies `done`: `new_base` valid |
| new_base | output | 32 | Updated base value |

## Verification
Beat k of a request (counting from 0) is due exactly k+1 cycles after the clock edge that captures `start`. Completion is due N+1 cycles after that edge, which is a single cycle for empty or illegal requests. A cycle counter is sampled at the negative edge when the driver raises `start`. The driver then queues each expected beat and completion together with its expected cycle stamp. The monitor samples on negative edges and compares each output it sees against the head of its queue, including that cycle stamp, so an early, late, missing or extra beat or completion is reported as a failure.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW   = 32,
  parameter int NR   = 16,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic [NR-1:0]     reg_mask,
  input  logic [1:0]        mode,
  input  logic              wback,
  input  logic              alt_state,
  input  logic [1:0]        pc_rule,
  output logic              busy,
  output logic              beat_valid,
  output logic [AW-1:0]     beat_addr,
  output logic [$clog2(NR)-1:0] beat_reg,
  output logic              done,
  output logic              illegal,
  output logic              wb_valid,
  output logic [AW-1:0]     new_base
);
  localparam int IW = $clog2(NR);
  localparam int CW = IW + 1;
  localparam int PC = NR - 1;

  logic [NR-1:0] pend;
  logic [AW-1:0] addr;
  logic          wb_pend;
  logic [CW-1:0] cnt;
  logic [AW-1:0] span, first_addr, final_base;
  logic [NR-1:0] low_bit, pend_next;
  logic          bad_mode, bad_pc, bad;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NR; i++) cnt = cnt + CW'(reg_mask[i]);
  end

  assign span = AW'(cnt) * AW'(STEP);

  always_comb begin
    case (mode)
      2'd1:    first_addr = base + AW'(STEP);
      2'd2:    first_addr = base - span + AW'(STEP);
      2'd3:    first_addr = base - span;
      default: first_addr = base;
    endcase
  end

  assign final_base = mode[1] ? base - span : base + span;
  assign bad_mode   = alt_state && mode[0];
  assign bad_pc     = (pc_rule == 2'd1 && reg_mask[PC]) || (pc_rule == 2'd2 && !reg_mask[PC]);
  assign bad        = bad_mode || bad_pc;

  assign low_bit   = pend & (~pend + NR'(1));
  assign pend_next = pend & ~low_bit;

  always_comb begin
    beat_reg = '0;
    for (int i = NR - 1; i >= 0; i--)
      if (pend[i]) beat_reg = IW'(i);
  end

  assign beat_valid = busy;
  assign beat_addr  = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      wb_valid <= 1'b0;
      wb_pend  <= 1'b0;
      pend     <= '0;
      addr     <= '0;
      new_base <= '0;
    end else begin
      done     <= 1'b0;
      illegal  <= 1'b0;
      wb_valid <= 1'b0;
      if (!busy && start) begin
        if (bad) begin
          done    <= 1'b1;
          illegal <= 1'b1;
        end else if (reg_mask == '0) begin
          done     <= 1'b1;
          wb_valid <= wback;
          new_base <= base;
        end else begin
          busy     <= 1'b1;
          pend     <= reg_mask;
          addr     <= first_addr;
          new_base <= final_base;
          wb_pend  <= wback;
        end
      end else if (busy) begin
        pend <= pend_next;
        addr <= addr + AW'(STEP);
        if (pend_next == '0) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          wb_valid <= wb_pend;
        end
      end
    end
  end

  p_reg_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> beat_reg > $past(beat_reg));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> beat_addr == $past(beat_addr) + AW'(STEP));

  p_wb_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done && !illegal);

  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !beat_valid);

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && $past(pend_next) != '0 |-> busy && !done);

  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  mode = '0;
  logic        wback = 1'b0;
  logic        alt_state = 1'b0;
  logic [1:0]  pc_rule = '0;
  logic        busy, beat_valid, done, illegal, wb_valid;
  logic [31:0] beat_addr, new_base;
  logic [3:0]  beat_reg;

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .reg_mask(reg_mask),
    .mode(mode), .wback(wback), .alt_state(alt_state), .pc_rule(pc_rule),
    .busy(busy), .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_reg(beat_reg),
    .done(done), .illegal(illegal), .wb_valid(wb_valid), .new_base(new_base));

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] q_addr[$];
  logic [3:0]  q_reg[$];
  int          q_bcyc[$];
  logic        q_ill[$];
  logic        q_wb[$];
  logic [31:0] q_base[$];
  int          q_dcyc[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_valid) begin
        if (q_addr.size() == 0) chk(0, "R2", "unexpected beat", {28'd0, beat_reg}, 32'hFFFF_FFFF);
        else begin
          chk(beat_addr == q_addr[0], "R3", "beat address", beat_addr, q_addr[0]);
          chk(beat_reg == q_reg[0], "R2", "beat register", {28'd0, beat_reg}, {28'd0, q_reg[0]});
          chk(cyc == q_bcyc[0], "R2", "beat cycle", cyc, q_bcyc[0]);
          void'(q_addr.pop_front()); void'(q_reg.pop_front()); void'(q_bcyc.pop_front());
        end
      end
      if (done) begin
        if (q_dcyc.size() == 0) chk(0, "R9", "unexpected done", 32'd1, 32'd0);
        else begin
          chk(cyc == q_dcyc[0], "R10", "done cycle", cyc, q_dcyc[0]);
          chk(busy == 1'b0, "R10", "busy at done", {31'd0, busy}, 32'd0);
          chk(illegal == q_ill[0], "R6 R7", "illegal flag", {31'd0, illegal}, {31'd0, q_ill[0]});
          chk(wb_valid == q_wb[0], "R5", "writeback flag", {31'd0, wb_valid}, {31'd0, q_wb[0]});
          if (q_wb[0]) chk(new_base == q_base[0], "R5 R8", "new base", new_base, q_base[0]);
          chk(q_addr.size() == 0, "R2", "beats left at done", q_addr.size(), 32'd0);
          void'(q_ill.pop_front()); void'(q_wb.pop_front());
          void'(q_base.pop_front()); void'(q_dcyc.pop_front());
        end
      end
    end
  end

  task automatic run(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                     input bit wb, input bit alt, input logic [1:0] rule, input bit poke);
    int n = 0;
    bit bad;
    logic [31:0] a;
    int c0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    bad = (alt && (md == 2'd1 || md == 2'd3)) ||
          (rule == 2'd1 && m[15]) || (rule == 2'd2 && !m[15]);
    @(negedge clk);
    c0 = cyc;
    if (md[1]) a = b - 32'(4 * n); else a = b;
    if (md == 2'd1 || md == 2'd2) a = a + 32'd4;
    if (!bad) begin
      int k = 0;
      for (int i = 0; i < 16; i++) if (m[i]) begin
        q_addr.push_back(a + 32'(4 * k));
        q_reg.push_back(4'(i));
        q_bcyc.push_back(c0 + 1 + k);
        k++;
      end
    end
    q_ill.push_back(bad);
    q_wb.push_back(!bad && wb);
    q_base.push_back(md[1] ? b - 32'(4 * n) : b + 32'(4 * n));
    q_dcyc.push_back(bad ? c0 + 1 : c0 + 1 + n);
    base = b; reg_mask = m; mode = md; wback = wb; alt_state = alt; pc_rule = rule;
    start = 1'b1;
    @(negedge clk);
    if (poke) begin
      base = 32'hDEAD_0000; reg_mask = 16'h0001; mode = 2'd3; wback = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    while (q_dcyc.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !wb_valid && !beat_valid, "R1", "reset outputs",
        {27'd0, busy, done, illegal, wb_valid, beat_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h0000_1000, 16'h00F1, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0); // R4 default incr-after
    run(32'h0000_2000, 16'h8003, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0); // R3 incr-before
    run(32'h0000_3000, 16'h0A50, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0); // R3 decr-after
    run(32'h0000_4000, 16'h0C03, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0); // R3 decr-before
    run(32'h0000_5000, 16'hFFFF, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0); // R5 no writeback
    run(32'h0000_0008, 16'h0007, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0); // R3 wrap
    run(32'h0000_6000, 16'h0003, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0); // R6 illegal
    run(32'h0000_6000, 16'h0003, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0); // R6 illegal
    run(32'h0000_6000, 16'h0003, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0); // R6 legal
    run(32'h0000_7000, 16'h8001, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0); // R7 forbid
    run(32'h0000_7000, 16'h0001, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0); // R7 require
    run(32'h0000_7000, 16'h8001, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0); // R7 require met
    run(32'h0000_7000, 16'h8001, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0); // R7 no rule
    run(32'h0000_8000, 16'h0000, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0); // R8 empty
    run(32'h0000_9000, 16'h00F0, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1); // R9 start ignored
    chk(q_addr.size() == 0 && q_dcyc.size() == 0, "R2", "queues drained",
        q_addr.size() + q_dcyc.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule